// File: doc/BRIEF.md
# Transmit Serial Data Intake

This block is the baseband-side receiver for the transmit payload that a MAC streams over a single serial line. The baseband owns the bit clock. It divides its system clock down to a serial clock and drives that clock out to the MAC. It then captures one data bit in the system-clock cycle where the serial clock goes from high to low.

A preamble/header generator elsewhere in the baseband reports completion with a one-cycle pulse. Only then does the block raise its ready output to invite payload. Ready is released as soon as the power-amplifier enable goes low, which marks the end of the transmission.

Captured bits are packed least-significant first. Every eighth bit yields a complete byte on a byte output, together with a one-cycle valid strobe. While ready is low, the serial clock is parked high and any partly assembled byte is dropped. Each new frame therefore starts cleanly at bit 0.

Top module: `tx_serial_intake`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising system-clock edge, drives ready low, the serial clock high, the byte strobe low and the byte output to zero, and empties any partial byte.
- R2: Ready rises one cycle after a header-done pulse that arrives while the amplifier enable is high; a header-done pulse while the amplifier enable is low has no effect.
- R3: Ready falls one cycle after the amplifier enable is seen low, and stays low while it remains low.
- R4: While ready is low, the serial clock output is held high and does not fall.
- R5: While ready is high, the serial clock toggles every CLK_DIV/2 system cycles, giving a period of CLK_DIV cycles. Its first fall comes CLK_DIV/2 cycles after ready rises.
- R6: A data bit is taken from the serial input at the system-clock edge on which the serial clock output changes from 1 to 0; a high level is a logic one.
- R7: Bits are packed least-significant first: the first bit captured in a byte becomes byte_o[0] and the eighth becomes byte_o[7].
- R8: The byte strobe is high for exactly one cycle, in the cycle the eighth bit is captured. byte_o carries the new byte in that cycle and holds it until the next strobe.
- R9: When ready drops, bits already captured for an incomplete byte are discarded, and the next frame starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_done | input | 1 | One-cycle pulse: preamble/header generation has finished |
| pa_en | input | 1 | Power-amplifier enable; high for the duration of a transmission |
| ser_din | input | 1 | Serial payload bit from the MAC (high = 1) |
| ser_clk_o | output | 1 | Serial bit clock driven to the MAC; idles high |
| ser_rdy_o | output | 1 | High when payload may be sent |
| byte_o | output | 8 | Most recently assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe marking a new byte on byte_o |

## Verification
The bench builds the block with CLK_DIV = 4, so each half period of the serial clock lasts two system cycles. This brings the edge-counter wrap and the fall-edge capture into play on nearly every bit, while a full byte still takes only 32 cycles. At that length, many frames fit in a short run: directed bytes, frames cut off mid-byte by the amplifier enable, resets in mid-frame, and a long stretch of random stimulus in which the data line changes on every cycle. Because the data line changes every cycle, a capture one cycle early or late gives the wrong byte.

// File: rtl/txi_pkg.sv
package txi_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_BITS);

    typedef logic [BYTE_BITS-1:0] txi_byte_t;
    typedef logic [BIT_IDX_W-1:0] txi_bidx_t;

endpackage

// File: rtl/txi_ready_ctl.sv
module txi_ready_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hdr_done,
    input  logic pa_en,
    output logic rdy_o
);

    typedef struct packed {
        logic rdy;
    } rdy_st_t;

    rdy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pa_en) begin
            st_d.rdy = 1'b0;
        end else if (hdr_done) begin
            st_d.rdy = 1'b1;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdy_o = st_q.rdy;

endmodule

// File: rtl/txi_clkgen.sv
module txi_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    generate
        if ((CLK_DIV < 2) || (CLK_DIV % 2 != 0)) begin : g_bad_div
            $error("CLK_DIV must be an even value of at least 2");
        end
    endgenerate

    typedef struct packed {
        logic             sclk;
        logic [CNT_W-1:0] cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    fall;

    always_comb begin
        st_d = st_q;
        fall = 1'b0;
        if (!run_i) begin
            st_d.sclk = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            fall      = st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!rst_n) begin
            st_d.sclk = 1'b1;
            st_d.cnt  = '0;
            fall      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
    assign fall_o = fall;

endmodule

// File: rtl/txi_deser.sv
module txi_deser
    import txi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      take_i,
    input  logic      din_i,
    output txi_byte_t byte_o,
    output logic      vld_o
);

    localparam txi_bidx_t LAST_BIT = BIT_IDX_W'(BYTE_BITS - 1);

    typedef struct packed {
        txi_byte_t sh;
        txi_bidx_t cnt;
        txi_byte_t out;
        logic      vld;
    } des_st_t;

    des_st_t   st_d, st_q;
    txi_byte_t nxt_sh;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        nxt_sh   = {din_i, st_q.sh[BYTE_BITS-1:1]};
        if (!run_i) begin
            st_d.sh  = '0;
            st_d.cnt = '0;
        end else if (take_i) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.out = nxt_sh;
                st_d.vld = 1'b1;
                st_d.sh  = '0;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = nxt_sh;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign byte_o = st_q.out;
    assign vld_o  = st_q.vld;

endmodule

// File: rtl/tx_serial_intake.sv
module tx_serial_intake #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_done,
    input  logic       pa_en,
    input  logic       ser_din,
    output logic       ser_clk_o,
    output logic       ser_rdy_o,
    output logic [7:0] byte_o,
    output logic       byte_vld_o
);

    logic rdy;
    logic fall;

    txi_ready_ctl u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_done (hdr_done),
        .pa_en    (pa_en),
        .rdy_o    (rdy)
    );

    txi_clkgen #(
        .CLK_DIV (CLK_DIV)
    ) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (rdy),
        .sclk_o (ser_clk_o),
        .fall_o (fall)
    );

    txi_deser u_des (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (rdy),
        .take_i (fall),
        .din_i  (ser_din),
        .byte_o (byte_o),
        .vld_o  (byte_vld_o)
    );

    assign ser_rdy_o = rdy;

endmodule

// File: rtl/txi_checker.sv
module txi_checker (
    input logic clk,
    input logic rst_n,
    input logic hdr_done,
    input logic pa_en,
    input logic ser_clk_o,
    input logic ser_rdy_o,
    input logic byte_vld_o
);

    p_rdy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_rdy_o) |-> ($past(hdr_done) && $past(pa_en)));

    p_rdy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_en |=> !ser_rdy_o);

    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_rdy_o |=> ser_clk_o);

    p_fall_needs_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk_o) |-> $past(ser_rdy_o));

    p_strobe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $fell(ser_clk_o));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

endmodule

bind tx_serial_intake txi_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_done   (hdr_done),
    .pa_en      (pa_en),
    .ser_clk_o  (ser_clk_o),
    .ser_rdy_o  (ser_rdy_o),
    .byte_vld_o (byte_vld_o)
);

// File: tb/sim_tx_serial_intake.sv
`timescale 1ns/1ps
module sim_tx_serial_intake;

    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_done = 1'b0;
    logic       pa_en = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_clk_o;
    logic       ser_rdy_o;
    logic [7:0] byte_o;
    logic       byte_vld_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int         m_rdy = 0;
    int         m_sclk = 1;
    int         m_cnt = 0;
    int         m_vld = 0;
    int         m_byte = 0;
    bit         bitq[$];
    logic       prev_sclk = 1'b1;

    always #10 clk = ~clk;

    tx_serial_intake #(.CLK_DIV(DIV)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_done   (hdr_done),
        .pa_en      (pa_en),
        .ser_din    (ser_din),
        .ser_clk_o  (ser_clk_o),
        .ser_rdy_o  (ser_rdy_o),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit fall;
        int nr;
        if (!rst_n) begin
            m_rdy = 0; m_sclk = 1; m_cnt = 0; m_vld = 0; m_byte = 0;
            bitq.delete();
            return;
        end
        m_vld = 0;
        fall = 0;
        if (m_rdy != 0) begin
            if (m_cnt == HALF - 1) begin
                fall = (m_sclk == 1);
                m_sclk = 1 - m_sclk;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (fall) begin
                bitq.push_back(ser_din);
                if (bitq.size() == 8) begin
                    m_byte = 0;
                    for (int i = 0; i < 8; i++) m_byte |= int'(bitq[i]) << i;
                    m_vld = 1;
                    bitq.delete();
                end
            end
        end else begin
            m_sclk = 1; m_cnt = 0;
            bitq.delete();
        end
        nr = m_rdy;
        if (!pa_en) nr = 0;
        else if (hdr_done) nr = 1;
        m_rdy = nr;
    endtask

    // one system cycle: model at the rising edge, compare at the falling edge
    task automatic step();
        prev_sclk = ser_clk_o;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(ser_rdy_o == m_rdy[0], "R2/R3", "model ready", ser_rdy_o, m_rdy);
        chk(ser_clk_o == m_sclk[0], "R4/R5", "model serial clock", ser_clk_o, m_sclk);
        chk(byte_vld_o == m_vld[0], "R8", "model strobe", byte_vld_o, m_vld);
        chk(byte_o == m_byte[7:0], "R7", "model byte", byte_o, m_byte);
    endtask

    task automatic wait_fall();
        do step(); while (!(prev_sclk && !ser_clk_o));
    endtask

    task automatic start_frame();
        pa_en = 1'b1; hdr_done = 1'b1;
        step();
        hdr_done = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        for (int i = 0; i < 8; i++) begin
            ser_din = b[i];
            wait_fall();
        end
        chk(byte_vld_o == 1'b1, req, "strobe after eighth bit", byte_vld_o, 1);
        chk(byte_o == b, req, "assembled byte", byte_o, b);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        int lfsr;
        int t0;
        rst_n = 1'b0;
        repeat (3) step();
        // R1 reset state
        chk(ser_rdy_o == 1'b0, "R1", "ready in reset", ser_rdy_o, 0);
        chk(ser_clk_o == 1'b1, "R1", "serial clock in reset", ser_clk_o, 1);
        chk(byte_vld_o == 1'b0 && byte_o == 8'h00, "R1", "byte in reset", byte_o, 0);
        rst_n = 1'b1;
        step();

        // R2: header pulse with amplifier off is ignored
        hdr_done = 1'b1; step(); hdr_done = 1'b0; step();
        chk(ser_rdy_o == 1'b0, "R2", "ready after ignored header", ser_rdy_o, 0);
        chk(ser_clk_o == 1'b1, "R4", "idle serial clock", ser_clk_o, 1);

        // R2 / R5: ready and first fall timing
        pa_en = 1'b1; hdr_done = 1'b1;
        step();
        hdr_done = 1'b0;
        chk(ser_rdy_o == 1'b1, "R2", "ready after header", ser_rdy_o, 1);
        t0 = cycles;
        wait_fall();
        chk(cycles - t0 == HALF, "R5", "cycles to first fall", cycles - t0, HALF);
        t0 = cycles;
        wait_fall();
        chk(cycles - t0 == DIV, "R5", "serial clock period", cycles - t0, DIV);
        pa_en = 1'b0; step(); step();

        // R6 / R7: directed bytes, LSB first, high = 1
        start_frame();
        send_byte(8'hA5, "R7");
        send_byte(8'h01, "R7");
        send_byte(8'h80, "R6");
        send_byte(8'hFF, "R6");
        // R8: strobe lasts one cycle, byte holds
        step();
        chk(byte_vld_o == 1'b0, "R8", "strobe after one cycle", byte_vld_o, 0);
        chk(byte_o == 8'hFF, "R8", "byte holds", byte_o, 8'hFF);

        // R3 / R9: drop amplifier mid-byte
        ser_din = 1'b1;
        repeat (3) wait_fall();
        pa_en = 1'b0;
        step();
        chk(ser_rdy_o == 1'b0, "R3", "ready after amplifier off", ser_rdy_o, 0);
        step();
        chk(ser_clk_o == 1'b1, "R4", "clock parked after ready drop", ser_clk_o, 1);
        start_frame();
        send_byte(8'h3C, "R9");

        // R1: reset mid-frame
        ser_din = 1'b1;
        repeat (2) wait_fall();
        rst_n = 1'b0;
        step();
        chk(ser_rdy_o == 1'b0 && ser_clk_o == 1'b1, "R1", "outputs after mid-frame reset",
            {ser_rdy_o, ser_clk_o}, 1);
        chk(byte_o == 8'h00, "R1", "byte after mid-frame reset", byte_o, 0);
        rst_n = 1'b1; pa_en = 1'b0;
        step();
        start_frame();
        send_byte(8'h5A, "R9");

        // random stretch against the model
        lfsr = 32'h1ACE5;
        for (int n = 0; n < 4000; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
            ser_din  = lfsr[3];
            hdr_done = (lfsr[9:5] == 5'd3);
            if (lfsr[17:10] == 8'h11) pa_en = ~pa_en;
            if (n % 700 == 350) pa_en = 1'b1;
            rst_n = !(lfsr[27:18] == 10'h2A5);
            step();
        end
        rst_n = 1'b1; hdr_done = 1'b0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule